// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block takes 8-bit control words from a host controller over a three-wire serial link: a data line, a shift clock and a latch strobe. All three lines are brought into the system clock domain through synchronizer chains. The block acts on the rising edges it detects there. Each shift-clock rise moves one data bit into an 8-bit shift register, with the first bit sent ending up in bit 0. On a rising edge of the strobe, the top bit of the word chooses where the word goes. A word with the top bit clear goes to the 7-bit attenuation target. A word with the top bit set goes to the mode flags: de-emphasis, a pair of bass-boost selects, mono, and the mono channel choice.

A mode pin decides where the settings come from. When it is high, the settings come straight from a set of parallel pins: mute, de-emphasis and the two bass-boost selects. When it is low, they come from the serial registers. In that case the pin that carries the second bass-boost select in parallel mode turns into a status output. The status is high whenever bass boost is not flat. An output-enable signal is provided for that shared pin.

All outputs are registered, so they change one system clock after the value they are built from. The downstream filters read these outputs and are not part of this block.

Top module: `serial_ctrl_port`

## Requirements
- R1: A bit is taken from `ser_dat` at each rising edge of `ser_clk`. The first bit sent lands in D0 and the eighth in D7. Only the eight most recent bits count, so a burst that is shorter or longer than eight clocks latches the last eight bits received.
- R2: The registers load only on a rising edge of `ser_le`. Shifting bits in with no strobe leaves every output unchanged.
- R3: A latched word with D7 = 0 sets `atten_target` = D6..D0. D6 is the most significant bit.
- R4: A latched word with D7 = 1 sets the flags and leaves the attenuation unchanged. D5 is de-emphasis on, D4 is bass flag 1, D3 is bass flag 2, D2 is mono, and D1 is the channel select (1 means right). D6 and D0 are ignored.
- R5: A latched word with D7 = 0 leaves all flags unchanged.
- R6: After reset the state is: attenuation 127, both bass flags 1, and de-emphasis, mono and channel select all 0.
- R7: `bass_mode` = {flag 1, flag 2}. The codes are 11 for flat 0 dB, 10 for minimum boost, 01 for maximum boost and 00 for flat -8 dB. In serial mode `bb_stat_out` is 0 only for code 11 and is 1 for every other code.
- R8: With `mode_par` = 1, the outputs follow the pins: `deemph_on` = `par_deemph`, `bass_mode` = {`par_bb1`, `par_bb2`}, and `mute_req` = `par_mute`. In this mode `atten_target` = 127, `mono_on` = 0, `chan_right` = 0, `bb_stat_oe` = 0 and `bb_stat_out` = 0.
- R9: With `mode_par` = 0, the outputs come from the registers, `mute_req` = 0 and `bb_stat_oe` = 1.
- R10: Serial words are still accepted while `mode_par` = 1. They show on the outputs once `mode_par` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_par | input | 1 | 1 selects the parallel pins, 0 selects the serial registers |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, D0 first |
| ser_le | input | 1 | Latch strobe; its rising edge loads the registers |
| par_mute | input | 1 | Parallel soft-mute request |
| par_deemph | input | 1 | Parallel de-emphasis enable |
| par_bb1 | input | 1 | Parallel bass select 1 |
| par_bb2 | input | 1 | Parallel bass select 2 (input side of the shared pin) |
| atten_target | output | 7 | Attenuation target, 127 = full level |
| deemph_on | output | 1 | De-emphasis enable |
| bass_mode | output | 2 | {bass flag 1, bass flag 2} |
| mono_on | output | 1 | Mono output enable |
| chan_right | output | 1 | Mono source: 1 = right, 0 = left |
| mute_req | output | 1 | Soft-mute request |
| bb_stat_out | output | 1 | Bass-boost active status (output side of the shared pin) |
| bb_stat_oe | output | 1 | Output enable for the shared pin |

## Verification
The hardest cases to reach are a burst whose length is not eight. In those cases the latched word is made of leftover bits from the previous word plus the new bits, so the bench first sets a known shift-register content. It then sends five-bit and ten-bit bursts whose expected result it works out from the shift order. The other hard case is a serial write made while the parallel pins are in control. The bench shows that this write had no visible effect, then drops the mode pin and checks that the stored value appears on the outputs.

// File: rtl/ctlif_pkg.sv
`timescale 1ns/1ps
package ctlif_pkg;
  localparam int ATT_W  = 7;
  localparam int WORD_W = ATT_W + 1;
  localparam int SEL_BIT = WORD_W - 1;
  localparam logic [ATT_W-1:0] ATT_FULL = {ATT_W{1'b1}};

  // flag bit positions inside a flag word
  localparam int POS_DEEMPH = 5;
  localparam int POS_BB1    = 4;
  localparam int POS_BB2    = 3;
  localparam int POS_MONO   = 2;
  localparam int POS_CHAN   = 1;

  typedef enum logic [1:0] {
    BASS_FLAT_LO = 2'b00,
    BASS_MAX     = 2'b01,
    BASS_MIN     = 2'b10,
    BASS_FLAT    = 2'b11
  } bass_e;

  typedef struct packed {
    logic  deemph;
    bass_e bass;
    logic  mono;
    logic  chan_r;
  } flags_t;

  localparam flags_t FLAGS_RST = '{deemph: 1'b0, bass: BASS_FLAT, mono: 1'b0, chan_r: 1'b0};
endpackage

// File: rtl/ctlif_sync.sv
`timescale 1ns/1ps
module ctlif_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
endmodule

// File: rtl/ctlif_edge.sv
`timescale 1ns/1ps
module ctlif_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;

  // a detected edge lasts exactly one cycle
  assert_single_rise_R1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ctlif_shift.sv
`timescale 1ns/1ps
module ctlif_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sh_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] sr_q;

  // newest bit enters at the top, so the first bit sent ends at bit 0
  always_ff @(posedge clk) begin
    if (rst)        sr_q <= '0;
    else if (sh_en) sr_q <= {din, sr_q[W-1:1]};
  end

  assign word = sr_q;

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !sh_en |=> $stable(sr_q));
endmodule

// File: rtl/ctlif_regs.sv
`timescale 1ns/1ps
module ctlif_regs
  import ctlif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              le_rise,
  input  logic [WORD_W-1:0] word,
  output logic [ATT_W-1:0]  atten,
  output flags_t            flags
);
  logic [ATT_W-1:0] atten_q;
  flags_t           flags_q;
  logic             is_flag_word;

  assign is_flag_word = word[SEL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      atten_q <= ATT_FULL;
    end else if (le_rise && !is_flag_word) begin
      atten_q <= word[ATT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= FLAGS_RST;
    end else if (le_rise && is_flag_word) begin
      flags_q.deemph <= word[POS_DEEMPH];
      flags_q.bass   <= bass_e'({word[POS_BB1], word[POS_BB2]});
      flags_q.mono   <= word[POS_MONO];
      flags_q.chan_r <= word[POS_CHAN];
    end
  end

  assign atten = atten_q;
  assign flags = flags_q;

  assert_flagword_keeps_atten_R4: assert property (@(posedge clk) disable iff (rst)
    (le_rise && word[SEL_BIT]) |=> $stable(atten_q));

  assert_attword_keeps_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (le_rise && !word[SEL_BIT]) |=> $stable(flags_q));

  assert_no_latch_no_change_R2: assert property (@(posedge clk) disable iff (rst)
    !le_rise |=> ($stable(atten_q) && $stable(flags_q)));
endmodule

// File: rtl/ctlif_select.sv
`timescale 1ns/1ps
module ctlif_select
  import ctlif_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_par,
  input  logic             par_mute,
  input  logic             par_deemph,
  input  logic             par_bb1,
  input  logic             par_bb2,
  input  logic [ATT_W-1:0] atten_reg,
  input  flags_t           flags_reg,
  output logic [ATT_W-1:0] atten_o,
  output logic             deemph_o,
  output logic [1:0]       bass_o,
  output logic             mono_o,
  output logic             chan_o,
  output logic             mute_o,
  output logic             stat_o,
  output logic             stat_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      atten_o  <= ATT_FULL;
      deemph_o <= 1'b0;
      bass_o   <= BASS_FLAT;
      mono_o   <= 1'b0;
      chan_o   <= 1'b0;
      mute_o   <= 1'b0;
      stat_o   <= 1'b0;
      stat_oe  <= 1'b0;
    end else if (mode_par) begin
      atten_o  <= ATT_FULL;
      deemph_o <= par_deemph;
      bass_o   <= {par_bb1, par_bb2};
      mono_o   <= 1'b0;
      chan_o   <= 1'b0;
      mute_o   <= par_mute;
      stat_o   <= 1'b0;
      stat_oe  <= 1'b0;
    end else begin
      atten_o  <= atten_reg;
      deemph_o <= flags_reg.deemph;
      bass_o   <= flags_reg.bass;
      mono_o   <= flags_reg.mono;
      chan_o   <= flags_reg.chan_r;
      mute_o   <= 1'b0;
      stat_o   <= (flags_reg.bass != BASS_FLAT);
      stat_oe  <= 1'b1;
    end
  end

  assert_stat_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !stat_oe |-> !stat_o);

  assert_par_stereo_R8: assert property (@(posedge clk) disable iff (rst)
    $past(mode_par) |-> (!mono_o && !chan_o));

  assert_serial_unmuted_R9: assert property (@(posedge clk) disable iff (rst)
    stat_oe |-> !mute_o);

  assert_flat_status_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_oe && bass_o == BASS_FLAT) |-> !stat_o);
endmodule

// File: rtl/serial_ctrl_port.sv
`timescale 1ns/1ps
module serial_ctrl_port
  import ctlif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_par,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  input  logic             par_mute,
  input  logic             par_deemph,
  input  logic             par_bb1,
  input  logic             par_bb2,
  output logic [ATT_W-1:0] atten_target,
  output logic             deemph_on,
  output logic [1:0]       bass_mode,
  output logic             mono_on,
  output logic             chan_right,
  output logic             mute_req,
  output logic             bb_stat_out,
  output logic             bb_stat_oe
);
  localparam int NSIG = 3;
  localparam int IX_DAT = 0;
  localparam int IX_CLK = 1;
  localparam int IX_LE  = 2;

  logic [NSIG-1:0]   lvl;
  logic              clk_rise;
  logic              le_rise;
  logic [WORD_W-1:0] word;
  logic [ATT_W-1:0]  atten_reg;
  flags_t            flags_reg;

  // data goes through the same number of stages as the clock, keeping them aligned
  ctlif_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ser_le, ser_clk, ser_dat}),
    .level    (lvl)
  );

  ctlif_edge u_clk_edge (
    .clk   (clk),
    .rst   (rst),
    .level (lvl[IX_CLK]),
    .rise  (clk_rise)
  );

  ctlif_edge u_le_edge (
    .clk   (clk),
    .rst   (rst),
    .level (lvl[IX_LE]),
    .rise  (le_rise)
  );

  ctlif_shift #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .sh_en (clk_rise),
    .din   (lvl[IX_DAT]),
    .word  (word)
  );

  ctlif_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .le_rise (le_rise),
    .word    (word),
    .atten   (atten_reg),
    .flags   (flags_reg)
  );

  ctlif_select u_sel (
    .clk        (clk),
    .rst        (rst),
    .mode_par   (mode_par),
    .par_mute   (par_mute),
    .par_deemph (par_deemph),
    .par_bb1    (par_bb1),
    .par_bb2    (par_bb2),
    .atten_reg  (atten_reg),
    .flags_reg  (flags_reg),
    .atten_o    (atten_target),
    .deemph_o   (deemph_on),
    .bass_o     (bass_mode),
    .mono_o     (mono_on),
    .chan_o     (chan_right),
    .mute_o     (mute_req),
    .stat_o     (bb_stat_out),
    .stat_oe    (bb_stat_oe)
  );
endmodule

// File: tb/serial_ctrl_port_tb.sv
`timescale 1ns/1ps
module serial_ctrl_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_par = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic par_mute = 1'b0, par_deemph = 1'b0, par_bb1 = 1'b0, par_bb2 = 1'b0;
  logic [6:0] atten_target;
  logic deemph_on, mono_on, chan_right, mute_req, bb_stat_out, bb_stat_oe;
  logic [1:0] bass_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_ctrl_port u_dut (
    .clk(clk), .rst(rst), .mode_par(mode_par),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .par_mute(par_mute), .par_deemph(par_deemph), .par_bb1(par_bb1), .par_bb2(par_bb2),
    .atten_target(atten_target), .deemph_on(deemph_on), .bass_mode(bass_mode),
    .mono_on(mono_on), .chan_right(chan_right), .mute_req(mute_req),
    .bb_stat_out(bb_stat_out), .bb_stat_oe(bb_stat_oe)
  );

  // vector: {word, expected attenuation, expected {deemph, bb1, bb2, mono, chan}}
  localparam logic [19:0] VEC [9] = '{
    {8'h00, 7'd0,   5'b01100},
    {8'h55, 7'd85,  5'b01100},
    {8'hA0, 7'd85,  5'b10000},
    {8'hFF, 7'd85,  5'b11111},
    {8'h7F, 7'd127, 5'b11111},
    {8'hC1, 7'd127, 5'b00000},
    {8'h94, 7'd127, 5'b01010},
    {8'h88, 7'd127, 5'b00100},
    {8'h01, 7'd1,   5'b00100}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = bits[i];
      ser_clk = 1'b0;
      tick(3);
      ser_clk = 1'b1;
      tick(3);
    end
    ser_clk = 1'b0;
    tick(3);
  endtask

  task automatic latch();
    ser_le = 1'b1;
    tick(3);
    ser_le = 1'b0;
    tick(8);
  endtask

  function automatic logic [4:0] flag_bits();
    return {deemph_on, bass_mode[1], bass_mode[0], mono_on, chan_right};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(4);
    // R6 reset state
    chk("R6 atten after reset", atten_target, 127);
    chk("R6 flags after reset", flag_bits(), 5'b01100);
    chk("R7 status flat after reset", bb_stat_out, 0);
    chk("R9 oe serial mode", bb_stat_oe, 1);
    chk("R9 mute low serial mode", mute_req, 0);

    // R3 R4 R5 table walk
    for (int v = 0; v < 9; v++) begin
      send_bits({8'h00, VEC[v][19:12]}, 8);
      latch();
      chk("R3/R5 atten vector", atten_target, VEC[v][11:5]);
      chk("R4 flags vector", flag_bits(), VEC[v][4:0]);
      chk("R7 status vector", bb_stat_out, (VEC[v][3] & VEC[v][2]) ? 0 : 1);
    end

    // R1 short burst: previous word 0x55 leaves bits 010 for the low end
    send_bits(16'h0055, 8);
    latch();
    chk("R1 setup word", atten_target, 85);
    send_bits(16'h000F, 5);
    latch();
    chk("R1 five-bit burst", atten_target, 122);

    // R1 long burst: only last eight of ten bits count
    send_bits(16'h00CF, 10);
    latch();
    chk("R1 ten-bit burst", atten_target, 51);

    // R2 shift without strobe
    send_bits(16'h0010, 8);
    tick(10);
    chk("R2 no strobe no change", atten_target, 51);
    latch();
    chk("R2 strobe loads", atten_target, 16);
    chk("R5 flags unchanged", flag_bits(), 5'b00100);

    // R8 parallel mode
    par_mute = 1'b1; par_deemph = 1'b1; par_bb1 = 1'b0; par_bb2 = 1'b1;
    mode_par = 1'b1;
    tick(3);
    chk("R8 deemph pin", deemph_on, 1);
    chk("R8 bass pins", bass_mode, 2'b01);
    chk("R8 mute pin", mute_req, 1);
    chk("R8 atten full", atten_target, 127);
    chk("R8 oe off", bb_stat_oe, 0);
    chk("R8 status off", bb_stat_out, 0);
    par_bb1 = 1'b1; par_bb2 = 1'b0; par_deemph = 1'b0;
    tick(3);
    chk("R8 bass pins change", bass_mode, 2'b10);
    chk("R8 deemph pin change", deemph_on, 0);

    // R10 serial write while parallel
    send_bits(16'h0084, 8);
    latch();
    chk("R10 mono hidden in parallel", mono_on, 0);
    mode_par = 1'b0;
    tick(3);
    chk("R10 mono after return", mono_on, 1);
    chk("R10 flags after return", flag_bits(), 5'b00010);
    chk("R9 atten from register", atten_target, 16);
    chk("R9 mute cleared", mute_req, 0);
    chk("R7 status boost", bb_stat_out, 1);
    chk("R9 oe back on", bb_stat_oe, 1);

    // R6 reset mid-run
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(3);
    chk("R6 atten after second reset", atten_target, 127);
    chk("R6 flags after second reset", flag_bits(), 5'b01100);
    chk("R7 status after second reset", bb_stat_out, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule